// File: doc/BRIEF.md
# Inter-Access Idle Cycle Inserter

This block sits between a request source and an external bus cycle engine and spaces consecutive bus accesses apart. It keeps the chip-select area and the direction of the last access it granted. When a new request arrives it picks a gap length from the configuration word of the new request's area, and it grants the request only after that many idle bus clocks have passed since the previous grant. The gap length depends on the pair of accesses: a write followed by anything, a read followed by a write, or a read followed by a read. For the last two the same-area case and the different-area case have separate fields.

Each area has one 32-bit configuration word. Each gap field in it is a 3-bit code n that asks for exactly n idle clocks. Clocks that pass with no request pending count toward the gap, so a request that comes late enough is granted at once. The request side uses a valid/ready handshake. The requester holds valid and the request fields steady until ready is seen. The `start` strobe marks the clock in which the engine may begin the granted access.

The control is a three-state machine. `ST_EMPTY` holds no history; it is entered from reset and grants at once. `ST_SETTLE` counts idle clocks since the last grant and grants once the count reaches the selected gap. `ST_QUIET` is entered when seven idle clocks have passed, which meets every possible gap, so it grants at once. The transitions are:

- EMPTY→SETTLE, SETTLE→SETTLE and QUIET→SETTLE happen on any grant, and the count restarts at zero.
- SETTLE→QUIET happens when the count passes six with no grant.
- EMPTY→EMPTY and QUIET→QUIET happen while nothing is granted.

Top module: `idle_gap_inserter`

## Requirements
- R1: The first request after reset is granted in the same clock it is presented, with no idle clocks.
- R2: After a write, the next access of either direction, to any area, waits for the code in bits 30:28 of the new area's word.
- R3: After a read, a write to a different area waits for the code in bits 26:24.
- R4: After a read, a write to the same area waits for the code in bits 22:20.
- R5: After a read, a read to a different area waits for the code in bits 18:16.
- R6: After a read, a read to the same area waits for the code in bits 14:12. A code of 0 grants back-to-back reads with no idle clock.
- R7: The gap is taken from the word of the new request's area. Area k's word occupies `cfg_words` bits 32k+31 to 32k.
- R8: An idle clock is any clock without a grant, whether or not a request is pending. A request is granted in the first clock in which the count of idle clocks since the last grant is at least the selected gap.
- R9: `start` is high exactly in clocks where `req_valid` and `req_ready` are both high. `busy` is high exactly when `req_valid` is high and `req_ready` is low. Both are low out of reset.
- R10: Bits of a configuration word outside the five gap fields have no effect on any grant timing.
- R11: A reset in mid-operation clears the history, so the next request is again granted with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_words | input | 32<<AREA_W | Per-area configuration words, area k at bits 32k+31:32k |
| req_valid | input | 1 | Request pending |
| req_write | input | 1 | Request direction, 1 = write |
| req_area | input | AREA_W | Chip-select area of the request |
| req_ready | output | 1 | Gap met; the request is accepted if valid |
| start | output | 1 | Grant strobe for the bus cycle engine |
| busy | output | 1 | Request held back by the idle gap |

## Verification
A wrong remembered area or direction selects the wrong field. This shows as a grant that comes early or late on the very next request. The bench sweeps every ordered pair of area and direction with distinct field values, so any such error changes a wait count at once. A stuck or miscounting idle counter shifts every grant after a nonzero gap. A state machine that fails to enter or leave `ST_QUIET` shows up as a late grant after long pauses. A missed return to `ST_EMPTY` on reset shows up as a nonzero wait on the first request after a reset.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;

    localparam int unsigned CFG_W = 32;
    localparam int unsigned GAP_W = 3;

    typedef enum logic [2:0] {
        XF_WW      = 3'd0,
        XF_RW_DIFF = 3'd1,
        XF_RW_SAME = 3'd2,
        XF_RR_DIFF = 3'd3,
        XF_RR_SAME = 3'd4
    } xfer_kind_e;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_SETTLE = 2'd1,
        ST_QUIET  = 2'd2
    } pace_state_e;

    function automatic int unsigned field_lsb(input xfer_kind_e kind);
        unique case (kind)
            XF_WW:      return 28;
            XF_RW_DIFF: return 24;
            XF_RW_SAME: return 20;
            XF_RR_DIFF: return 16;
            XF_RR_SAME: return 12;
            default:    return 28;
        endcase
    endfunction

endpackage

// File: rtl/ig_history.sv
module ig_history #(
    parameter int AREA_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [AREA_W-1:0] commit_area,
    input  logic              commit_write,
    output logic [AREA_W-1:0] last_area,
    output logic              last_write
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_area  <= '0;
            last_write <= 1'b0;
        end else if (commit) begin
            last_area  <= commit_area;
            last_write <= commit_write;
        end
    end

endmodule

// File: rtl/ig_gap_select.sv
module ig_gap_select
    import idle_gap_pkg::*;
#(
    parameter int AREA_W = 2
) (
    input  logic [(CFG_W<<AREA_W)-1:0] cfg_words,
    input  logic [AREA_W-1:0]          new_area,
    input  logic                       new_write,
    input  logic [AREA_W-1:0]          last_area,
    input  logic                       last_write,
    output logic [GAP_W-1:0]           gap
);

    localparam int NUM_AREAS = 1 << AREA_W;

    logic [CFG_W-1:0] word_arr [NUM_AREAS];
    logic [CFG_W-1:0] sel_word;
    xfer_kind_e       kind;
    logic             same_area;
    logic             sel_unused;

    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_unpack
        assign word_arr[g] = cfg_words[g*CFG_W +: CFG_W];
    end

    assign sel_word  = word_arr[new_area];
    assign same_area = (new_area == last_area);

    always_comb begin
        if (last_write) begin
            kind = XF_WW;
        end else if (new_write) begin
            kind = same_area ? XF_RW_SAME : XF_RW_DIFF;
        end else begin
            kind = same_area ? XF_RR_SAME : XF_RR_DIFF;
        end
    end

    assign gap = sel_word[field_lsb(kind) +: GAP_W];

    // bits outside the gap fields carry no meaning here
    assign sel_unused = ^{sel_word[31], sel_word[27], sel_word[23],
                          sel_word[19], sel_word[15], sel_word[11:0]};

endmodule

// File: rtl/ig_pace_fsm.sv
module ig_pace_fsm
    import idle_gap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [GAP_W-1:0] gap,
    output logic             ready,
    output logic             accept,
    output logic             hold
);

    localparam logic [GAP_W-1:0] CNT_LAST = GAP_W'((1 << GAP_W) - 2);

    pace_state_e      state, state_nx;
    logic [GAP_W-1:0] idle_cnt, idle_cnt_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_EMPTY;
            idle_cnt <= '0;
        end else begin
            state    <= state_nx;
            idle_cnt <= idle_cnt_nx;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_EMPTY:  ready = 1'b1;
            ST_SETTLE: ready = (idle_cnt >= gap);
            ST_QUIET:  ready = 1'b1;
            default:   ready = 1'b0;
        endcase
        accept = req_valid && ready;
        hold   = req_valid && !ready;
    end

    // transitions
    always_comb begin
        state_nx    = state;
        idle_cnt_nx = idle_cnt;
        unique case (state)
            ST_EMPTY: begin
                if (accept) begin
                    state_nx    = ST_SETTLE;
                    idle_cnt_nx = '0;
                end
            end
            ST_SETTLE: begin
                if (accept) begin
                    idle_cnt_nx = '0;
                end else if (idle_cnt == CNT_LAST) begin
                    state_nx    = ST_QUIET;
                    idle_cnt_nx = idle_cnt + 1'b1;
                end else begin
                    idle_cnt_nx = idle_cnt + 1'b1;
                end
            end
            ST_QUIET: begin
                if (accept) begin
                    state_nx    = ST_SETTLE;
                    idle_cnt_nx = '0;
                end
            end
            default: begin
                state_nx    = ST_EMPTY;
                idle_cnt_nx = '0;
            end
        endcase
    end

endmodule

// File: rtl/idle_gap_inserter.sv
module idle_gap_inserter
    import idle_gap_pkg::*;
#(
    parameter int AREA_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [(CFG_W<<AREA_W)-1:0] cfg_words,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [AREA_W-1:0]          req_area,
    output logic                       req_ready,
    output logic                       start,
    output logic                       busy
);

    logic [AREA_W-1:0] last_area;
    logic              last_write;
    logic [GAP_W-1:0]  gap;

    ig_history #(.AREA_W(AREA_W)) u_hist (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit       (start),
        .commit_area  (req_area),
        .commit_write (req_write),
        .last_area    (last_area),
        .last_write   (last_write)
    );

    ig_gap_select #(.AREA_W(AREA_W)) u_sel (
        .cfg_words  (cfg_words),
        .new_area   (req_area),
        .new_write  (req_write),
        .last_area  (last_area),
        .last_write (last_write),
        .gap        (gap)
    );

    ig_pace_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .gap       (gap),
        .ready     (req_ready),
        .accept    (start),
        .hold      (busy)
    );

endmodule

// File: rtl/ig_checker.sv
module ig_checker #(
    parameter int AREA_W = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [(32<<AREA_W)-1:0] cfg_words,
    input logic                    req_valid,
    input logic                    req_write,
    input logic [AREA_W-1:0]       req_area,
    input logic                    req_ready,
    input logic                    start,
    input logic                    busy
);

    logic              c_first;
    logic              c_last_wr;
    logic [AREA_W-1:0] c_last_area;
    logic [2:0]        c_idle;
    logic [31:0]       c_word;

    assign c_word = cfg_words[32*int'(req_area) +: 32];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_first     <= 1'b1;
            c_last_wr   <= 1'b0;
            c_last_area <= '0;
            c_idle      <= '0;
        end else if (start) begin
            c_first     <= 1'b0;
            c_last_wr   <= req_write;
            c_last_area <= req_area;
            c_idle      <= '0;
        end else if (c_idle != 3'd7) begin
            c_idle      <= c_idle + 3'd1;
        end
    end

    // R1
    first_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && c_first) |-> req_ready);

    // R2
    ww_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !c_first && c_last_wr) |-> (c_idle >= c_word[30:28]));

    // R6
    rr_same_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !c_first && !c_last_wr && !req_write &&
         req_area == c_last_area && c_word[14:12] == 3'd0) |-> req_ready);

    // R8
    gap_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && c_idle == 3'd7) |-> req_ready);

    // R9
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (req_valid && !start));

endmodule

bind idle_gap_inserter ig_checker #(.AREA_W(AREA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_words (cfg_words),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_area  (req_area),
    .req_ready (req_ready),
    .start     (start),
    .busy      (busy)
);

// File: tb/idle_gap_inserter_bench.sv
module idle_gap_inserter_bench;

    localparam int AREA_W = 2;
    localparam int NA     = 1 << AREA_W;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [32*NA-1:0]     cfg_words = '0;
    logic                 req_valid = 1'b0;
    logic                 req_write = 1'b0;
    logic [AREA_W-1:0]    req_area = '0;
    logic                 req_ready, start, busy;

    int  n_checks = 0;
    int  n_bad    = 0;
    bit  done     = 1'b0;

    bit  m_first;
    bit  m_last_wr;
    int  m_last_area;
    int  pass_no;
    bit  after_reset;

    always #4 clk = ~clk;

    idle_gap_inserter #(.AREA_W(AREA_W)) u_idle_gap_inserter (
        .clk(clk), .rst_n(rst_n), .cfg_words(cfg_words),
        .req_valid(req_valid), .req_write(req_write), .req_area(req_area),
        .req_ready(req_ready), .start(start), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int field(input int area, input int lsb);
        return int'(cfg_words[area*32 + lsb +: 3]);
    endfunction

    // field lsb per kind: WW 28, RW diff 24, RW same 20, RR diff 16, RR same 12
    function automatic void make_cfg(input int p);
        int lsbs [5] = '{28, 24, 20, 16, 12};
        for (int a = 0; a < NA; a++) begin
            logic [31:0] w;
            w = (p != 0) ? ~32'h7777_7000 : 32'h0;
            for (int k = 0; k < 5; k++) begin
                int v;
                v = (a*3 + k*5 + p*2 + 1) % 8;
                if (k == 4 && a == 0) v = 0;
                w[lsbs[k] +: 3] = 3'(v);
            end
            cfg_words[a*32 +: 32] = w;
        end
    endfunction

    task automatic access(input int area, input bit wr, input int pre);
        int    w, exp, gap;
        string tag;
        for (int i = 0; i < pre; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            check(busy == 1'b0 && start == 1'b0, "R9 idle outputs", {busy, start}, 0);
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_area  = AREA_W'(area);
        #1;
        w = 0;
        while (!req_ready && w < 20) begin
            check(busy == 1'b1 && start == 1'b0, "R9 waiting outputs", {busy, start}, 2);
            @(negedge clk);
            #1;
            w++;
        end
        check(start == 1'b1 && busy == 1'b0, "R9 grant outputs", {busy, start}, 1);
        if (m_first) begin
            gap = 0;
            tag = after_reset ? "R11" : "R1";
        end else if (m_last_wr) begin
            gap = field(area, 28); tag = "R2";
        end else if (wr) begin
            gap = (area == m_last_area) ? field(area, 20) : field(area, 24);
            tag = (area == m_last_area) ? "R4" : "R3";
        end else begin
            gap = (area == m_last_area) ? field(area, 12) : field(area, 16);
            tag = (area == m_last_area) ? "R6" : "R5";
        end
        exp = (gap > pre) ? gap - pre : 0;
        tag = $sformatf("%s R7%s%s area=%0d wr=%0d pre=%0d", tag,
                        (pre > 0) ? " R8" : "", (pass_no != 0) ? " R10" : "",
                        area, wr, pre);
        check(w == exp, tag, w, exp);
        m_first     = 1'b0;
        m_last_wr   = wr;
        m_last_area = area;
    endtask

    task automatic do_reset();
        @(negedge clk);
        req_valid = 1'b0;
        rst_n     = 1'b0;
        repeat (2) @(negedge clk);
        rst_n     = 1'b1;
        m_first   = 1'b1;
    endtask

    initial begin
        int pres [4] = '{0, 1, 3, 8};
        m_first = 1'b1; m_last_wr = 1'b0; m_last_area = 0;
        pass_no = 0; after_reset = 1'b0;
        make_cfg(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(busy == 1'b0 && start == 1'b0, "R9 reset state", {busy, start}, 0);
        for (int p = 0; p < 2; p++) begin
            pass_no = p;
            make_cfg(p);
            for (int pa = 0; pa < NA; pa++)
                for (int pw = 0; pw < 2; pw++)
                    for (int na = 0; na < NA; na++)
                        for (int nw = 0; nw < 2; nw++)
                            for (int q = 0; q < 4; q++) begin
                                access(pa, bit'(pw), 0);
                                access(na, bit'(nw), pres[q]);
                            end
        end
        // R6: back-to-back reads to area 0 with zero same-area read gap
        access(0, 1'b0, 0);
        access(0, 1'b0, 0);
        access(0, 1'b0, 0);
        // R11: reset mid-run clears history
        access(1, 1'b1, 0);
        do_reset();
        after_reset = 1'b1;
        #1;
        check(busy == 1'b0 && start == 1'b0, "R11 reset outputs", {busy, start}, 0);
        access(1, 1'b0, 0);
        access(2, 1'b1, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule